// File: doc/BRIEF.md
# Halving Tree Reduction Sequencer

This block adds up to `NUM_MAX` partial values, which arrive together on one wide bus with a start pulse and an active count. The values go into a bank of registers. The block then reduces them with a halving schedule that runs one step per clock. Every pairwise adder of a step works in the same cycle, and each step finishes before the next begins.

When the active count is odd, position 0 first takes in the last active element. The count is then halved with integer division. Each position below the new count adds in its partner, which sits the new count places above it. Steps repeat until one element remains. That element is the total, which is presented with a one-cycle done pulse. Addition wraps modulo 2^`DATA_W`.

A count that is not a power of two therefore reduces with no padding. A start pulse that arrives while a reduction is running has no effect.

Top module: `tree_reduce_seq`

## Requirements
- R1: When `done_o` is high, `sum_o` equals the sum modulo 2^`DATA_W` of the elements at indices 0 to n-1 of `vals_i`, where n is the effective count. Element i occupies bits [i*DATA_W +: DATA_W]. Elements at index n and above do not change the result.
- R2: Odd counts and counts that are not powers of two produce the correct total, including when the last active element is the only nonzero one.
- R3: Let the start be sampled at clock edge t. Then `done_o` is high in the cycle that follows edge t+S, where S = max(1, floor(log2 n)).
- R4: `done_o` is high for exactly one cycle. `sum_o` keeps its value in the following idle cycles until the next accepted start.
- R5: `busy_o` is high in every cycle from edge t+1 up to edge t+S, and is low in the done cycle. A start pulse while `busy_o` is high is ignored, together with its count and values.
- R6: With n = 1, the block finishes after a single step and returns element 0.
- R7: A `count_i` of 0 is treated as 1. A `count_i` above `NUM_MAX` is treated as `NUM_MAX`.
- R8: A start pulse in the cycle where `done_o` is high is accepted. `sum_o` still shows the finished total in that cycle.
- R9: After reset, `busy_o` and `done_o` are low and `sum_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; loads count and values when idle |
| count_i | input | $clog2(NUM_MAX+1) | Number of active elements |
| vals_i | input | NUM_MAX*DATA_W | Partial values, element i at bits [i*DATA_W +: DATA_W] |
| busy_o | output | 1 | Reduction in progress |
| done_o | output | 1 | One-cycle pulse: result valid |
| sum_o | output | DATA_W | Reduction result |

## Verification
The completion of one reduction and the acceptance of the next start can fall in the same cycle. The bench provokes this by raising `start_i` exactly in the cycle where `done_o` is high. In that cycle it checks that `sum_o` still holds the finished total. It then checks that the new job returns its own total after its own step count. A second coincidence is a start that arrives while `busy_o` is high: it carries a different count and different values, and the bench judges it by the first job's total and timing staying unchanged.

// File: rtl/red_pkg.sv
package red_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } red_state_e;
endpackage

// File: rtl/red_fold_unit.sv
// Folds the stranded top element into position 0 when the count is odd.
module red_fold_unit #(
  parameter int NUM_MAX = 8,
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 4
) (
  input  logic [NUM_MAX*DATA_W-1:0] regs_i,
  input  logic [CNT_W-1:0]          cnt_i,
  output logic [DATA_W-1:0]         fold0_o
);
  logic [DATA_W-1:0] last_val;

  always_comb begin
    last_val = '0;
    for (int i = 0; i < NUM_MAX; i++) begin
      if (i + 1 == int'(cnt_i)) last_val = regs_i[i*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    if (cnt_i[0] && cnt_i > CNT_W'(1))
      fold0_o = regs_i[0 +: DATA_W] + last_val;
    else
      fold0_o = regs_i[0 +: DATA_W];
  end
endmodule

// File: rtl/red_pair_lane.sv
// One lower-half position: adds its partner located half places above.
module red_pair_lane #(
  parameter int NUM_MAX = 8,
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 4,
  parameter int POS     = 0
) (
  input  logic [DATA_W-1:0]         own_i,
  input  logic [NUM_MAX*DATA_W-1:0] regs_i,
  input  logic [CNT_W-1:0]          half_i,
  output logic [DATA_W-1:0]         nxt_o
);
  logic [DATA_W-1:0] partner;

  always_comb begin
    partner = '0;
    for (int i = POS + 1; i < NUM_MAX; i++) begin
      if (i == POS + int'(half_i)) partner = regs_i[i*DATA_W +: DATA_W];
    end
  end

  assign nxt_o = (POS < int'(half_i)) ? own_i + partner : own_i;
endmodule

// File: rtl/tree_reduce_seq.sv
module tree_reduce_seq #(
  parameter int NUM_MAX = 8,
  parameter int DATA_W  = 16,
  localparam int CNT_W  = $clog2(NUM_MAX + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic [CNT_W-1:0]          count_i,
  input  logic [NUM_MAX*DATA_W-1:0] vals_i,
  output logic                      busy_o,
  output logic                      done_o,
  output logic [DATA_W-1:0]         sum_o
);
  import red_pkg::*;

  localparam int LANES = NUM_MAX / 2;

  red_state_e               state_q;
  logic [CNT_W-1:0]         cnt_q;
  logic                     done_q;
  logic [NUM_MAX*DATA_W-1:0] regs_q;
  logic [NUM_MAX*DATA_W-1:0] regs_nxt;
  logic [CNT_W-1:0]         half;
  logic [CNT_W-1:0]         eff_cnt;
  logic [DATA_W-1:0]        fold0;
  logic                     accept;

  assign half   = cnt_q >> 1;
  assign accept = (state_q == ST_IDLE) && start_i;

  always_comb begin
    if (count_i == '0)                  eff_cnt = CNT_W'(1);
    else if (count_i > CNT_W'(NUM_MAX)) eff_cnt = CNT_W'(NUM_MAX);
    else                                eff_cnt = count_i;
  end

  red_fold_unit #(
    .NUM_MAX(NUM_MAX), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_fold (
    .regs_i (regs_q),
    .cnt_i  (cnt_q),
    .fold0_o(fold0)
  );

  for (genvar p = 0; p < NUM_MAX; p++) begin : g_pos
    if (p < LANES) begin : g_lane
      logic [DATA_W-1:0] own;
      if (p == 0) begin : g_own0
        assign own = fold0;
      end else begin : g_ownn
        assign own = regs_q[p*DATA_W +: DATA_W];
      end
      red_pair_lane #(
        .NUM_MAX(NUM_MAX), .DATA_W(DATA_W), .CNT_W(CNT_W), .POS(p)
      ) u_lane (
        .own_i (own),
        .regs_i(regs_q),
        .half_i(half),
        .nxt_o (regs_nxt[p*DATA_W +: DATA_W])
      );
    end else begin : g_keep
      assign regs_nxt[p*DATA_W +: DATA_W] = regs_q[p*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      regs_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        regs_q  <= vals_i;
        cnt_q   <= eff_cnt;
        state_q <= ST_RUN;
      end else if (state_q == ST_RUN) begin
        if (cnt_q <= CNT_W'(1)) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end else begin
          regs_q <= regs_nxt;
          cnt_q  <= half;
          if (half == CNT_W'(1)) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
      end
    end
  end

  assign busy_o = (state_q == ST_RUN);
  assign done_o = done_q;
  assign sum_o  = regs_q[0 +: DATA_W];
endmodule

// File: rtl/tree_reduce_seq_chk.sv
module tree_reduce_seq_chk #(
  parameter int CNT_W  = 4,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [CNT_W-1:0]  count_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [DATA_W-1:0] sum_o,
  input logic [CNT_W-1:0]  cnt_q
);
  a_r4_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r4_sum_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(sum_o));

  a_r5_not_busy_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r5_halving_ignores_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cnt_q > CNT_W'(1)) |=> (cnt_q == ($past(cnt_q) >> 1)));

  a_r8_accept_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);

  a_r6_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && count_i <= CNT_W'(1)) |=> busy_o ##1 done_o);
endmodule

bind tree_reduce_seq tree_reduce_seq_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .count_i(count_i),
  .busy_o (busy_o),
  .done_o (done_o),
  .sum_o  (sum_o),
  .cnt_q  (cnt_q)
);

// File: tb/tb_tree_reduce_seq.sv
`timescale 1ns/1ps
module tb_tree_reduce_seq;
  localparam int NMAX = 8;
  localparam int DW   = 16;
  localparam int CW   = $clog2(NMAX + 1);

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               start_i = 1'b0;
  logic [CW-1:0]      count_i = '0;
  logic [NMAX*DW-1:0] vals_i = '0;
  logic               busy_o, done_o;
  logic [DW-1:0]      sum_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  tree_reduce_seq #(.NUM_MAX(NMAX), .DATA_W(DW)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .count_i(count_i),
    .vals_i(vals_i), .busy_o(busy_o), .done_o(done_o), .sum_o(sum_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff_of(input int n);
    if (n == 0) return 1;
    if (n > NMAX) return NMAX;
    return n;
  endfunction

  function automatic int steps_of(input int e);
    int s = 0;
    int v = e;
    while (v > 1) begin v = v / 2; s++; end
    return (s < 1) ? 1 : s;
  endfunction

  function automatic logic [DW-1:0] elem(input int pat, input int i, input int e);
    case (pat)
      0:       return DW'((i + 1) * 4369 + e * 3);
      1:       return DW'(16'hFFFF - i);
      2:       return (i == e - 1) ? DW'(16'hA5A5) : ((i >= e) ? DW'(16'h7777) : '0);
      default: return DW'(i * 911 + 77);
    endcase
  endfunction

  function automatic logic [NMAX*DW-1:0] pack(input int pat, input int e);
    logic [NMAX*DW-1:0] v = '0;
    for (int i = 0; i < NMAX; i++) v[i*DW +: DW] = elem(pat, i, e);
    return v;
  endfunction

  function automatic logic [DW-1:0] expect_sum(input int pat, input int e);
    logic [DW-1:0] s = '0;
    for (int i = 0; i < e; i++) s = s + elem(pat, i, e);
    return s;
  endfunction

  // Drive a job, optionally try a start while busy; check timing and total.
  task automatic run(input int n, input int pat, input bit inject, input string tag);
    int e = eff_of(n);
    int lat;
    logic [DW-1:0] exp_s = expect_sum(pat, e);
    @(negedge clk_i);
    start_i = 1'b1; count_i = CW'(n); vals_i = pack(pat, e);
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 1;
    chk(busy_o == 1'b1, "R5 busy after start", int'(busy_o), 1);
    if (inject) begin
      start_i = 1'b1; count_i = CW'(NMAX); vals_i = pack(3, NMAX);
    end
    while (!done_o && lat < 40) begin
      @(negedge clk_i);
      start_i = 1'b0;
      lat++;
    end
    chk(lat == steps_of(e) + 1, {tag, " R3 latency"}, lat, steps_of(e) + 1);
    chk(sum_o == exp_s, {tag, " R1 total"}, int'(sum_o), int'(exp_s));
    chk(busy_o == 1'b0, "R5 idle at done", int'(busy_o), 0);
    @(negedge clk_i);
    chk(done_o == 1'b0, "R4 done one cycle", int'(done_o), 0);
    chk(sum_o == exp_s, "R4 sum held", int'(sum_o), int'(exp_s));
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1;
    chk(busy_o == 1'b0, "R9 reset busy", int'(busy_o), 0);
    chk(done_o == 1'b0, "R9 reset done", int'(done_o), 0);
    chk(sum_o == '0, "R9 reset sum", int'(sum_o), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 R2 R7: sweep every count code over several patterns
    for (int n = 0; n < (1 << CW); n++) begin
      for (int pat = 0; pat < 3; pat++) begin
        run(n, pat, 1'b0, (pat == 2) ? "R2 stranded" : "R1 sweep");
      end
    end
    // R6: single element
    run(1, 0, 1'b0, "R6 single");
    run(0, 1, 1'b0, "R7 zero count");
    run(12, 0, 1'b0, "R7 clamp");
    // R5: start while busy is ignored
    for (int n = 1; n <= NMAX; n++) run(n, 1, 1'b1, "R5 ignore start");

    // R8: start in the done cycle
    begin
      int lat;
      @(negedge clk_i);
      start_i = 1'b1; count_i = CW'(5); vals_i = pack(0, 5);
      @(negedge clk_i);
      start_i = 1'b0;
      lat = 1;
      while (!done_o && lat < 40) begin @(negedge clk_i); lat++; end
      chk(sum_o == expect_sum(0, 5), "R8 total in done cycle", int'(sum_o), int'(expect_sum(0, 5)));
      start_i = 1'b1; count_i = CW'(8); vals_i = pack(1, 8);
      @(negedge clk_i);
      start_i = 1'b0;
      chk(busy_o == 1'b1, "R8 accepted at done", int'(busy_o), 1);
      lat = 1;
      while (!done_o && lat < 40) begin @(negedge clk_i); lat++; end
      chk(lat == 4, "R8 second latency", lat, 4);
      chk(sum_o == expect_sum(1, 8), "R8 second total", int'(sum_o), int'(expect_sum(1, 8)));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule